// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Late Write

This block is a synchronous single-port memory whose read data follows the clocked address within the same cycle, with no output register. Write data arrives one cycle after its address, so a read may follow a write, or a write a read, on consecutive clock edges with no idle cycle between them. The storage is small and its depth, lane count and lane width are parameters.

An access starts when the load control is low at an enabled edge. That edge samples the address, the read/write select, the byte strobes, the burst order pin and the three chip selects. With the load control high, each later edge moves to the next word of the same group of four. The word is chosen by a two-bit beat count, applied to the low address bits in either interleaved or linear order. The clock-enable input can freeze every register for any number of edges. A sleep input parks the block while it is deselected.

The two data buses are kept apart. The output valid flag shows when the read bus would be driving a shared bidirectional bus.

Top module: `fts_burst_ram`

## Requirements
- R1: A read loaded at an enabled edge shows its word on `dataOut` during the cycle after that same edge, with `dataOutEn` high, when `outEnN` is low.
- R2: Write data is taken from `dataIn` at the enabled edge after the one that loaded the write. A read loaded at that edge to the same address returns the new data at once.
- R3: Lane b is bits [9b+8:9b] and is written only when `byteWrN[b]` was low at the edge that issued the write beat. With every strobe high, the write is aborted and the word is left unchanged.
- R4: `advLoadN` low loads the address and sets the beat count to 0. `advLoadN` high adds 1 to the beat count modulo 4 and keeps the operation type, the selection result and the address bits above bit 1.
- R5: If `seqMode` was high at the load, the low two address bits are the loaded low bits XOR the beat count.
- R6: If `seqMode` was low at the load, the low two address bits are the loaded low bits plus the beat count, modulo 4.
- R7: An edge with `clkEnN` high changes nothing: address, beat, operation, memory and outputs all keep their values.
- R8: A load with `chipSelN0` high, `chipSel1` low or `chipSelN2` high deselects the block. No access takes place, outputs stay off, and later advance edges keep it deselected.
- R9: `dataOutEn` is high only for a read with `outEnN` low and `sleep` low, so it is low during every write data phase. `dataOut` is all zeros whenever `dataOutEn` is low.
- R10: While `sleep` is high, edges start no access and commit no write, and outputs are off. After sleep ends, a deselected block keeps its outputs off, and memory contents are retained.
- R11: While `rstN` is low, no access is active and `dataOutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset of control state, active low |
| clkEnN | input | 1 | Clock enable, active low; high ignores the edge |
| chipSelN0 | input | 1 | Chip select, active low |
| chipSel1 | input | 1 | Chip select, active high |
| chipSelN2 | input | 1 | Chip select, active low |
| wrSelN | input | 1 | Read (high) or write (low), sampled at load |
| byteWrN | input | LANES | Per-lane write strobes, active low |
| advLoadN | input | 1 | Low loads a new address; high advances the burst |
| seqMode | input | 1 | Burst order: high interleaved, low linear |
| sleep | input | 1 | Sleep request, only while deselected |
| outEnN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, one cycle after its address |
| dataOut | output | LANES*LANE_W | Flow-through read data, zero when off |
| dataOutEn | output | 1 | Read bus would drive |

## Verification
A read result is due in the same cycle as the edge that loaded or advanced it. The bench therefore samples a quarter period after each edge and compares against a model already updated for that edge. A write becomes visible one enabled edge after its address edge, so the model commits the lanes using the `dataIn` present at that later edge. Each stalled or sleeping edge delays every pending result by one cycle, and the model handles this by skipping its update on those edges. The output flag and zeroed data follow `outEnN` and `sleep` in the same cycle, and are checked at the same sampling point.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic readOn;    // drive read word this cycle
    logic commitWr;  // write laneMask at this edge
  } ramStrobe_t;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq (
  input  logic [1:0] startLow,
  input  logic [1:0] beat,
  input  logic       interleave,
  output logic [1:0] curLow
);
  always_comb begin
    if (interleave) curLow = startLow ^ beat;
    else            curLow = 2'(startLow + beat);
  end
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int AW = 5,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkEnN,
  input  logic          sleep,
  input  logic          chipSelN0,
  input  logic          chipSel1,
  input  logic          chipSelN2,
  input  logic          wrSelN,
  input  logic          advLoadN,
  input  logic          seqMode,
  input  logic          outEnN,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byteWrN,
  output ramStrobe_t    strobe,
  output logic [AW-1:0] curAddr,
  output logic [NB-1:0] laneMask
);
  logic          stepEn;
  logic          selNow;
  opKind_e       opQ;
  logic [AW-1:0] baseQ;
  logic [1:0]    beatQ;
  logic          interQ;
  logic [NB-1:0] lanesQ;
  logic [1:0]    curLow;

  assign stepEn = !clkEnN && !sleep;
  assign selNow = !chipSelN0 && chipSel1 && !chipSelN2;

  fts_burst_seq i_seq (
    .startLow  (baseQ[1:0]),
    .beat      (beatQ),
    .interleave(interQ),
    .curLow    (curLow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= OP_IDLE;
      baseQ  <= '0;
      beatQ  <= 2'd0;
      interQ <= 1'b1;
      lanesQ <= '0;
    end else if (stepEn) begin
      lanesQ <= ~byteWrN;
      if (!advLoadN) begin
        baseQ  <= addr;
        beatQ  <= 2'd0;
        interQ <= seqMode;
        if (!selNow)     opQ <= OP_IDLE;
        else if (wrSelN) opQ <= OP_READ;
        else             opQ <= OP_WRITE;
      end else begin
        beatQ <= 2'(beatQ + 2'd1);
      end
    end
  end

  assign curAddr         = {baseQ[AW-1:2], curLow};
  assign laneMask        = lanesQ;
  assign strobe.readOn   = (opQ == OP_READ) && !outEnN && !sleep;
  assign strobe.commitWr = stepEn && (opQ == OP_WRITE);
endmodule

// File: rtl/fts_datapath.sv
module fts_datapath
  import fts_pkg::*;
#(
  parameter int AW = 5,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  ramStrobe_t       strobe,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    laneMask,
  input  logic [NB*LW-1:0] dataIn,
  output logic [NB*LW-1:0] dataOut
);
  localparam int DEPTH = 1 << AW;
  logic [NB*LW-1:0] rdWord;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LW-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.commitWr && laneMask[b])
        laneMem[addr] <= dataIn[b*LW +: LW];
    end
    assign rdWord[b*LW +: LW] = laneMem[addr];
  end

  assign dataOut = strobe.readOn ? rdWord : '0;
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      clkEnN,
  input  logic                      chipSelN0,
  input  logic                      chipSel1,
  input  logic                      chipSelN2,
  input  logic                      wrSelN,
  input  logic [LANES-1:0]          byteWrN,
  input  logic                      advLoadN,
  input  logic                      seqMode,
  input  logic                      sleep,
  input  logic                      outEnN,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   dataIn,
  output logic [LANES*LANE_W-1:0]   dataOut,
  output logic                      dataOutEn
);
  ramStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic [LANES-1:0]  laneMask;

  fts_ctrl #(.AW(ADDR_W), .NB(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
    .chipSelN0(chipSelN0), .chipSel1(chipSel1), .chipSelN2(chipSelN2),
    .wrSelN(wrSelN), .advLoadN(advLoadN), .seqMode(seqMode),
    .outEnN(outEnN), .addr(addr), .byteWrN(byteWrN),
    .strobe(strobe), .curAddr(rdAddr), .laneMask(laneMask)
  );

  fts_datapath #(.AW(ADDR_W), .NB(LANES), .LW(LANE_W)) i_dp (
    .clk(clk), .strobe(strobe), .addr(rdAddr), .laneMask(laneMask),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assign dataOutEn = strobe.readOn;
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
  parameter int AW = 5,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rstN,
  input logic          clkEnN,
  input logic          sleep,
  input logic          chipSelN0,
  input logic          chipSel1,
  input logic          chipSelN2,
  input logic          wrSelN,
  input logic          advLoadN,
  input logic          outEnN,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] curAddr,
  input logic [DW-1:0] dataOut,
  input logic          dataOutEn
);
  logic stepNow, selNow;
  assign stepNow = !clkEnN && !sleep;
  assign selNow  = !chipSelN0 && chipSel1 && !chipSelN2;

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (!outEnN && !sleep));
  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == '0));
  assert_write_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !advLoadN && selNow && !wrSelN) |=> !dataOutEn);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(curAddr));
  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> $stable(curAddr));
  assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOutEn);
  assert_load_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !advLoadN) |=> (curAddr == $past(addr)));
  assert_advance_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && advLoadN) |=> (curAddr[AW-1:2] == $past(curAddr[AW-1:2])));
  assert_deselect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !advLoadN && !selNow) |=> !dataOutEn);
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.AW(ADDR_W), .DW(LANES*LANE_W)) i_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .sleep(sleep),
  .chipSelN0(chipSelN0), .chipSel1(chipSel1), .chipSelN2(chipSelN2),
  .wrSelN(wrSelN), .advLoadN(advLoadN), .outEnN(outEnN),
  .addr(addr), .curAddr(rdAddr), .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/test_fts_burst_ram.sv
module test_fts_burst_ram;
  localparam int PER   = 10;
  localparam int AW    = 5;
  localparam int NB    = 4;
  localparam int LW    = 9;
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN;
  logic clkEnN, chipSelN0, chipSel1, chipSelN2, wrSelN, advLoadN, seqMode, sleep, outEnN;
  logic [NB-1:0] byteWrN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic          dataOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] mMem [DEPTH];
  int            mOp;      // 0 idle, 1 read, 2 write
  logic [AW-1:0] mBase;
  logic [1:0]    mBeat;
  logic          mInter;
  logic [NB-1:0] mLanes;

  always #(PER/2) clk = ~clk;

  fts_burst_ram #(.ADDR_W(AW), .LANES(NB), .LANE_W(LW)) i_fts_burst_ram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipSelN0(chipSelN0),
    .chipSel1(chipSel1), .chipSelN2(chipSelN2), .wrSelN(wrSelN),
    .byteWrN(byteWrN), .advLoadN(advLoadN), .seqMode(seqMode),
    .sleep(sleep), .outEnN(outEnN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  function automatic logic [AW-1:0] modelAddr();
    logic [1:0] low;
    low = mInter ? (mBase[1:0] ^ mBeat) : 2'(mBase[1:0] + mBeat);
    return {mBase[AW-1:2], low};
  endfunction

  function automatic logic [DW-1:0] rndData();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one clock: drive inputs, update model at the edge, sample a quarter period later
  task automatic tick(input logic ceN, input logic slp, input logic c0N, input logic c1,
                      input logic c2N, input logic wN, input logic ldN, input logic md,
                      input logic oeN, input logic [AW-1:0] a, input logic [NB-1:0] bwN,
                      input logic [DW-1:0] d, input string tagIn);
    string tag;
    logic  expEn;
    clkEnN = ceN; sleep = slp; chipSelN0 = c0N; chipSel1 = c1; chipSelN2 = c2N;
    wrSelN = wN; advLoadN = ldN; seqMode = md; outEnN = oeN; addr = a;
    byteWrN = bwN; dataIn = d;
    @(posedge clk);
    if (!ceN && !slp) begin
      if (mOp == 2) begin
        for (int b = 0; b < NB; b++)
          if (mLanes[b]) mMem[modelAddr()][b*LW +: LW] = d[b*LW +: LW];
      end
      mLanes = ~bwN;
      if (!ldN) begin
        mBase = a; mBeat = 2'd0; mInter = md;
        mOp = (!c0N && c1 && !c2N) ? (wN ? 1 : 2) : 0;
      end else begin
        mBeat = 2'(mBeat + 2'd1);
      end
    end
    #(PER/4);
    if (tagIn != "") tag = tagIn;
    else if (ceN)    tag = "R7 stall";
    else if (slp)    tag = "R10 sleep";
    else if (mOp == 1) tag = (mBeat == 0) ? "R1 read" : (mInter ? "R5 interleaved" : "R6 linear");
    else if (mOp == 2) tag = "R9 write phase";
    else               tag = "R8 deselected";
    expEn = (mOp == 1) && !oeN && !slp;
    check({tag, " enable"}, DW'(dataOutEn), DW'(expEn));
    check({tag, " data"}, dataOut, expEn ? mMem[modelAddr()] : '0);
  endtask

  task automatic ldOp(input logic wr, input logic [AW-1:0] a, input logic [NB-1:0] bwN,
                      input logic md, input logic [DW-1:0] d, input string tag);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, !wr, 1'b0, md, 1'b0, a, bwN, d, tag);
  endtask

  task automatic advOp(input logic [NB-1:0] bwN, input logic [DW-1:0] d, input string tag);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, bwN, d, tag);
  endtask

  task automatic idleLd(input logic [DW-1:0] d, input string tag);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, '1, d, tag);
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'd1355));
    mOp = 0; mBase = '0; mBeat = 2'd0; mInter = 1'b1; mLanes = '0;
    rstN = 1'b0; clkEnN = 1'b0; sleep = 1'b0; chipSelN0 = 1'b1; chipSel1 = 1'b1;
    chipSelN2 = 1'b0; wrSelN = 1'b1; advLoadN = 1'b0; seqMode = 1'b1; outEnN = 1'b0;
    addr = '0; byteWrN = '1; dataIn = '0;
    repeat (3) @(posedge clk);
    #(PER/4);
    check("R11 reset enable", DW'(dataOutEn), '0);
    check("R11 reset data", dataOut, '0);
    rstN = 1'b1;

    // fill memory with back-to-back full writes
    for (int a = 0; a < DEPTH; a++) ldOp(1'b1, AW'(a), '0, 1'b1, rndData(), "R9 fill");
    idleLd(rndData(), "R2 fill commit");

    // R2: write followed at once by a read of the same address
    ldOp(1'b1, 5'd9, '0, 1'b1, rndData(), "R9 write phase");
    ldOp(1'b0, 5'd9, '1, 1'b1, rndData(), "R2 read after write");
    // R2: read, write, read interleaved with no gap
    ldOp(1'b1, 5'd3, '0, 1'b0, rndData(), "R9 write phase");
    ldOp(1'b0, 5'd4, '1, 1'b0, rndData(), "R2 read between writes");
    ldOp(1'b0, 5'd3, '1, 1'b0, rndData(), "R2 read back");

    // R3: partial lanes, then abort
    ldOp(1'b1, 5'd12, 4'b1010, 1'b1, rndData(), "R9 write phase");
    ldOp(1'b0, 5'd12, '1, 1'b1, rndData(), "R3 lanes 0 and 2 written");
    ldOp(1'b1, 5'd12, 4'b1111, 1'b1, rndData(), "R9 write phase");
    ldOp(1'b0, 5'd12, '1, 1'b1, rndData(), "R3 abort keeps word");

    // R4 / R5: interleaved read burst from low bits 2, with wrap
    ldOp(1'b0, 5'd22, '1, 1'b1, rndData(), "R4 burst load");
    for (int i = 0; i < 4; i++) advOp('1, rndData(), "R5 interleaved beat");
    // R4 / R6: linear read burst from low bits 3
    ldOp(1'b0, 5'd7, '1, 1'b0, rndData(), "R4 burst load");
    for (int i = 0; i < 4; i++) advOp('1, rndData(), "R6 linear beat");
    // linear write burst then verify
    ldOp(1'b1, 5'd17, '0, 1'b0, rndData(), "R9 write phase");
    for (int i = 0; i < 3; i++) advOp('0, rndData(), "R9 burst write phase");
    ldOp(1'b0, 5'd17, '1, 1'b0, rndData(), "R6 burst write readback");
    for (int i = 0; i < 3; i++) advOp('1, rndData(), "R6 burst write readback");

    // R7: stall mid-burst and during a write data phase
    ldOp(1'b0, 5'd28, '1, 1'b1, rndData(), "R1 read");
    advOp('1, rndData(), "R5 interleaved beat");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd1, '0, rndData(), "R7 stall holds read");
    tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2, '0, rndData(), "R7 stall holds read");
    advOp('1, rndData(), "R7 resume burst");
    ldOp(1'b1, 5'd30, '0, 1'b1, rndData(), "R9 write phase");
    tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, '1, rndData(), "R7 stall in data phase");
    ldOp(1'b0, 5'd30, '1, 1'b1, rndData(), "R7 data taken after stall");

    // R8: each chip select deselects, burst continues stay deselected
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd5, '1, rndData(), "R8 csN0 high");
    advOp('1, rndData(), "R8 advance stays off");
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd5, '1, rndData(), "R8 cs1 low");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd5, '0, rndData(), "R8 csN2 high write ignored");
    ldOp(1'b0, 5'd5, '1, 1'b1, rndData(), "R8 word unchanged");

    // R9: output enable high during a read
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd6, '1, rndData(), "R9 outEnN high");

    // R10: sleep while deselected, attempted loads ignored
    idleLd(rndData(), "R8 deselect before sleep");
    for (int i = 0; i < 3; i++)
      tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6, '0, rndData(), "R10 sleep ignores load");
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, '1, rndData(), "R10 off after sleep");
    ldOp(1'b0, 5'd6, '1, 1'b1, rndData(), "R10 memory retained");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 16;
      w = rndData();
      if (r == 0)
        tick(1'b1, 1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'b0, AW'($urandom), NB'($urandom), w, "");
      else if (r == 1 && mOp == 0)
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0,
             AW'($urandom), NB'($urandom), w, "");
      else if (r == 2 || r == 3) begin
        logic [2:0] cs;
        cs = 3'($urandom % 3);
        tick(1'b0, 1'b0, cs == 0, cs != 1, cs == 2, 1'($urandom), 1'b0, 1'($urandom), 1'b0,
             AW'($urandom), NB'($urandom), w, "");
      end else if (r >= 4 && r <= 8)
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'($urandom), ($urandom % 8) == 0,
             AW'($urandom), NB'($urandom), w, "");
      else if (r >= 9 && r <= 12)
        ldOp(1'b1, AW'($urandom), NB'($urandom), 1'($urandom), w, "");
      else
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, ($urandom % 8) == 0,
             AW'($urandom), NB'($urandom), w, "");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule